// File: doc/BRIEF.md
# Programmable Peripheral Interrupt Router

The router takes a wide set of level-sensitive peripheral interrupt lines and places each one onto one of seven general-purpose core interrupt levels, numbered 7 through 13. Each source has a 4-bit routing code that software can rewrite, and a mask bit. A level line is raised whenever at least one unmasked source routed to that level is active. Reset loads a fixed routing in which faults sit at the most urgent level and bulk memory traffic sits at the least urgent.

The sources are split into groups of 32. Each group holds its own mask word, its own read-only raw-status word and its own block of routing words. The outputs of all groups are ORed onto the same seven level lines. A small synchronous register port reaches every register. Writes land on the rising clock edge and reads are combinational. The level outputs are combinational from the sources and the registers, so a changed mask or route acts in the cycle after the write edge.

Top module: `irq_router`

## Requirements
- R1: After reset every mask bit is 0, both mask words read 0x00000000, and all seven `lvl_req` bits stay 0 whatever `irq_src` carries.
- R2: Routing codes encode level minus 7, so code 0 means level 7 and code 6 means level 13. After reset the codes are: sources 0–14 code 0, sources 15–16 code 1, sources 17–24 code 2, sources 25–34 code 3, sources 35–39 code 4, source 40 code 5, sources 41–45 code 6, and sources 46–63 code 0xF.
- R3: The mask word of group g is at word address 16·g+0. Bit n enables source 32·g+n when it is 1 and blocks it when it is 0. The word reads back what was written.
- R4: The routing words of group g are at addresses 16·g+8+k for k = 0..3. Bits 4j+3:4j hold the code of source 32·g+8k+j. A written word reads back unchanged.
- R5: `lvl_req[i]` (level 7+i) is the OR of `irq_src[s]` over every source s whose mask bit is 1 and whose code equals i.
- R6: A source whose code is 7 to 15 drives no level, even when it is unmasked and active.
- R7: Address 16·g+1 returns the raw `irq_src` bits of group g whatever the mask. Writes to it have no effect.
- R8: A new code acts from the clock edge that writes it. Before that edge the old level is driven. A source never drives two levels in the same cycle.
- R9: Unmapped addresses read 0. A write with `bus_en` low changes nothing.
- R10: Sources in different groups that carry the same code drive the same level line together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Word address: bit 4 selects the group, bits 3:0 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_src | input | 64 | Peripheral interrupt request levels |
| lvl_req | output | 7 | Level requests; bit i is core level 7+i |

## Verification
A corrupted routing code moves a source's request to another `lvl_req` bit, or drops it. The error shows in the same cycle the source goes active, and also on a read of the routing word. A stuck or lost mask bit either passes a request through or blocks it, again as soon as that source asserts. Because the outputs are combinational, a write that lands one edge late shows as the old level still driven just after the write edge. The bench checks on both sides of that edge.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int NLVL    = 7;
  localparam int FIELD_W = 4;

  // reset routing code for a global source index (level minus 7, 0xF = off)
  function automatic logic [FIELD_W-1:0] reset_code(input int src);
    if (src <= 14)      return FIELD_W'(0);
    else if (src <= 16) return FIELD_W'(1);
    else if (src <= 24) return FIELD_W'(2);
    else if (src <= 34) return FIELD_W'(3);
    else if (src <= 39) return FIELD_W'(4);
    else if (src == 40) return FIELD_W'(5);
    else if (src <= 45) return FIELD_W'(6);
    else                return {FIELD_W{1'b1}};
  endfunction

  // one-hot level vector for one active, enabled source
  function automatic logic [NLVL-1:0] level_vec(input logic [FIELD_W-1:0] code,
                                                input logic live);
    logic [NLVL-1:0] v;
    for (int l = 0; l < NLVL; l++) v[l] = live && (code == FIELD_W'(l));
    return v;
  endfunction
endpackage

// File: rtl/irq_route_slice.sv
module irq_route_slice
  import irq_router_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FIELD_W-1:0] code,
  input  logic               en_bit,
  input  logic               src_bit,
  output logic [NLVL-1:0]    route
);
  logic live;
  assign live  = en_bit & src_bit;
  assign route = level_vec(code, live);

  a_r8_single_level: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(route));
  a_r6_invalid_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (code >= FIELD_W'(NLVL)) |-> (route == '0));
  a_r5_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_bit || !src_bit) |-> (route == '0));
endmodule

// File: rtl/irq_route_group.sv
module irq_route_group
  import irq_router_pkg::*;
#(
  parameter int GRP_IDX = 0,
  parameter int GRP_W   = 32,
  parameter int DATA_W  = 32,
  localparam int FPW     = DATA_W / FIELD_W,
  localparam int WORDS   = (GRP_W + FPW - 1) / FPW,
  localparam int WSEL_W  = (WORDS > 1) ? $clog2(WORDS) : 1
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_mask,
  input  logic                     wr_code,
  input  logic [WSEL_W-1:0]        code_word,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [GRP_W-1:0]         src,
  output logic [GRP_W-1:0]         mask_q,
  output logic [WORDS*DATA_W-1:0]  code_flat,
  output logic [NLVL-1:0]          lvl_out
);
  logic [FIELD_W-1:0] code_q [GRP_W];
  logic [NLVL-1:0]    route_w [GRP_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (wr_mask) begin
      mask_q <= wdata[GRP_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < GRP_W; i++) code_q[i] <= reset_code(GRP_IDX*GRP_W + i);
    end else if (wr_code) begin
      for (int i = 0; i < GRP_W; i++)
        if (WSEL_W'(i / FPW) == code_word)
          code_q[i] <= wdata[(i % FPW)*FIELD_W +: FIELD_W];
    end
  end

  always_comb begin
    code_flat = '0;
    for (int i = 0; i < GRP_W; i++) code_flat[i*FIELD_W +: FIELD_W] = code_q[i];
  end

  for (genvar i = 0; i < GRP_W; i++) begin : g_slice
    irq_route_slice u_slice (
      .clk     (clk),
      .rst_n   (rst_n),
      .code    (code_q[i]),
      .en_bit  (mask_q[i]),
      .src_bit (src[i]),
      .route   (route_w[i])
    );
  end

  always_comb begin
    lvl_out = '0;
    for (int i = 0; i < GRP_W; i++) lvl_out = lvl_out | route_w[i];
  end

  a_r3_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask_q == $past(wdata[GRP_W-1:0])));
  a_r4_code_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_code && code_word == '0) |=> (code_flat[DATA_W-1:0] == $past(wdata)));
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NSRC   = 64,
  parameter int GRP_W  = 32,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  localparam int NGRP   = NSRC / GRP_W,
  localparam int FPW    = DATA_W / FIELD_W,
  localparam int WORDS  = (GRP_W + FPW - 1) / FPW,
  localparam int WSEL_W = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int GSEL_W = ADDR_W - 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NSRC-1:0]   irq_src,
  output logic [NLVL-1:0]   lvl_req
);
  localparam logic [3:0] OFF_MASK = 4'd0;
  localparam logic [3:0] OFF_STAT = 4'd1;
  localparam logic [3:0] OFF_CODE = 4'd8;

  logic [3:0]        off;
  logic [GSEL_W-1:0] gsel;
  logic              is_code;
  logic [WSEL_W-1:0] wsel;

  assign off     = bus_addr[3:0];
  assign gsel    = bus_addr[ADDR_W-1:4];
  assign is_code = (off >= OFF_CODE) && (off < OFF_CODE + 4'(WORDS));
  assign wsel    = WSEL_W'(off - OFF_CODE);

  logic [GRP_W-1:0]        grp_mask [NGRP];
  logic [WORDS*DATA_W-1:0] grp_code [NGRP];
  logic [NLVL-1:0]         grp_lvl  [NGRP];

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic hit;
    assign hit = bus_en && bus_we && (gsel == GSEL_W'(g));
    irq_route_group #(.GRP_IDX(g), .GRP_W(GRP_W), .DATA_W(DATA_W)) u_grp (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_mask   (hit && off == OFF_MASK),
      .wr_code   (hit && is_code),
      .code_word (wsel),
      .wdata     (bus_wdata),
      .src       (irq_src[g*GRP_W +: GRP_W]),
      .mask_q    (grp_mask[g]),
      .code_flat (grp_code[g]),
      .lvl_out   (grp_lvl[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (gsel == GSEL_W'(g)) begin
        if (off == OFF_MASK)      bus_rdata = DATA_W'(grp_mask[g]);
        else if (off == OFF_STAT) bus_rdata = DATA_W'(irq_src[g*GRP_W +: GRP_W]);
        else if (is_code)         bus_rdata = grp_code[g][wsel*DATA_W +: DATA_W];
      end
    end
  end

  always_comb begin
    lvl_req = '0;
    for (int g = 0; g < NGRP; g++) lvl_req = lvl_req | grp_lvl[g];
  end

  a_r7_status_raw: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && bus_addr == ADDR_W'(OFF_STAT)) |-> (bus_rdata == irq_src[DATA_W-1:0]));
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && off > OFF_STAT && off < OFF_CODE) |-> (bus_rdata == '0));
  a_r5_quiet_sources: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_src == '0) |-> (lvl_req == '0));
endmodule

// File: tb/irq_router_bench.sv
module irq_router_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_en = 0, bus_we = 0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] irq_src = '0;
  logic [6:0]  lvl_req;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_router u_irq_router (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_src(irq_src), .lvl_req(lvl_req)
  );

  typedef struct packed { logic [63:0] src; logic [6:0] lvl; } vec_t;
  localparam vec_t VECS [10] = '{
    '{64'h1,                 7'b0000001},
    '{64'h8000,              7'b0000010},
    '{64'h10_0000,           7'b0000100},
    '{64'h2_0000_0000,       7'b0001000},
    '{64'h10_0000_0000,      7'b0010000},
    '{64'h100_0000_0000,     7'b0100000},
    '{64'h2000_0000_0000,    7'b1000000},
    '{64'h4_0000_0000_0000,  7'b0000000},
    '{64'h1_4000,            7'b0000011},
    '{{64{1'b1}},            7'b1111111}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a;
    #2 d = bus_rdata;
    bus_en = 0;
  endtask

  task automatic drive_src(input logic [63:0] s);
    @(negedge clk);
    irq_src = s;
    #2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    irq_src = {64{1'b1}};
    repeat (3) @(posedge clk);
    #2 chk("R1 lvl in reset", 64'(lvl_req), 64'h0);
    @(negedge clk); rst_n = 1;
    #2 chk("R1 lvl after reset", 64'(lvl_req), 64'h0);
    rd(5'd0, d);  chk("R1 mask0", 64'(d), 64'h0);
    rd(5'd16, d); chk("R1 mask1", 64'(d), 64'h0);

    // R2 reset routing words
    rd(5'd8,  d); chk("R2 word g0k0", 64'(d), 64'h0000_0000);
    rd(5'd9,  d); chk("R2 word g0k1", 64'(d), 64'h1000_0000);
    rd(5'd10, d); chk("R2 word g0k2", 64'(d), 64'h2222_2221);
    rd(5'd11, d); chk("R2 word g0k3", 64'(d), 64'h3333_3332);
    rd(5'd24, d); chk("R2 word g1k0", 64'(d), 64'h4444_4333);
    rd(5'd25, d); chk("R2 word g1k1", 64'(d), 64'hFF66_6665);
    rd(5'd26, d); chk("R2 word g1k2", 64'(d), 64'hFFFF_FFFF);

    wr(5'd0, 32'hFFFF_FFFF);
    wr(5'd16, 32'hFFFF_FFFF);
    rd(5'd16, d); chk("R3 mask1 readback", 64'(d), 64'hFFFF_FFFF);

    // R5 default-routing vectors
    foreach (VECS[i]) begin
      drive_src(VECS[i].src);
      chk($sformatf("R5 vector %0d", i), 64'(lvl_req), 64'(VECS[i].lvl));
    end

    // R3 per-bit masking
    wr(5'd0, 32'h0000_0001); wr(5'd16, 32'h0);
    drive_src({64{1'b1}});
    chk("R3 only src0 enabled", 64'(lvl_req), 64'b0000001);
    wr(5'd0, 32'h0); wr(5'd16, 32'h0000_0100);
    #2 chk("R3 only src40 enabled", 64'(lvl_req), 64'b0100000);
    wr(5'd0, 32'hFFFF_FFFF); wr(5'd16, 32'hFFFF_FFFF);

    // R7 raw status
    wr(5'd0, 32'h0); wr(5'd16, 32'h0);
    drive_src(64'hA5A5_0000_1234_5678);
    rd(5'd1,  d); chk("R7 status g0", 64'(d), 64'h1234_5678);
    rd(5'd17, d); chk("R7 status g1", 64'(d), 64'hA5A5_0000);
    wr(5'd1, 32'h0);
    rd(5'd1,  d); chk("R7 status write ignored", 64'(d), 64'h1234_5678);
    wr(5'd0, 32'hFFFF_FFFF); wr(5'd16, 32'hFFFF_FFFF);

    // R9 unmapped reads, gated write
    rd(5'd5,  d); chk("R9 unmapped 5", 64'(d), 64'h0);
    rd(5'd12, d); chk("R9 unmapped 12", 64'(d), 64'h0);
    @(negedge clk); bus_en = 0; bus_we = 1; bus_addr = 5'd0; bus_wdata = 32'h0;
    @(negedge clk); bus_we = 0;
    rd(5'd0, d); chk("R9 write without enable", 64'(d), 64'hFFFF_FFFF);

    // R4 routing word write/readback, R6 invalid codes
    wr(5'd8, 32'h7654_3210);
    rd(5'd8, d); chk("R4 word readback", 64'(d), 64'h7654_3210);
    drive_src(64'h80);
    chk("R6 code 7 silent", 64'(lvl_req), 64'h0);
    drive_src(64'h7F);
    chk("R4 codes 0..6 on src0..6", 64'(lvl_req), 64'b1111111);
    wr(5'd8, 32'h0000_000F);
    drive_src(64'h1);
    chk("R6 code F silent", 64'(lvl_req), 64'h0);

    // R8 timing of a re-route
    wr(5'd8, 32'h0);
    #2 chk("R8 src0 at level 7", 64'(lvl_req), 64'b0000001);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = 5'd8; bus_wdata = 32'h6;
    #2 chk("R8 old level before edge", 64'(lvl_req), 64'b0000001);
    @(negedge clk); bus_en = 0; bus_we = 0;
    #2 chk("R8 new level after edge", 64'(lvl_req), 64'b1000000);

    // R10 groups share level lines
    wr(5'd8, 32'h4);
    drive_src(64'h1);
    chk("R10 g0 src0 level 11", 64'(lvl_req), 64'b0010000);
    drive_src(64'h10_0000_0000);
    chk("R10 g1 src36 level 11", 64'(lvl_req), 64'b0010000);
    drive_src(64'h10_0000_0003);
    chk("R10 both groups merged", 64'(lvl_req), 64'b0010001);

    finish_run();
  end
endmodule